// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block gathers level-sensitive interrupt request lines from up to sixteen peripherals and drives one interrupt line to a processor core. It can run in one of two modes, chosen by a control bit. In the flat mode, the core is interrupted whenever any enabled source is requesting. Software then reads the pending bitmap to find the cause. In the ranked mode, every source carries a programmable priority and a programmable handler address. The core is interrupted only when the best pending source strictly outranks the handler now in service.

When the core acknowledges, the controller returns the handler address of the winning source on the next cycle, so software does not have to scan for the cause. In ranked mode the acknowledge also pushes the winner's priority onto an internal stack of in-service levels. A write to the end-of-service register pops that stack and restores the previous threshold, which is how nested handlers unwind. If nothing deserves service at the moment of the acknowledge, a programmable default address is returned instead.

All configuration is reached through a word-addressed register port. Writes take effect on the clock edge. Reads are combinational on the address.

Top module: `prio_vic`

## Requirements
- R1: Each request line is sampled on the rising clock edge, so `irq` responds one cycle after a line changes. A source counts as pending only while its sampled line is high.
- R2: The enable register at address 0x00 holds one bit per source, with bit i for source i. A source whose bit is 0 never raises `irq` and never wins an acknowledge.
- R3: Address 0x01 reads back the pending bitmap, which is the sampled request lines ANDed with the enable bits.
- R4: With control register 0x05 bit 0 cleared (flat mode), `irq` is high exactly when the pending bitmap is nonzero. Priority values do not matter in this mode.
- R5: With control bit 0 set (ranked mode), sources with priority 0 are ignored. `irq` is high only when the best eligible priority is strictly greater than the current threshold. The threshold is 0 when nothing is in service. An equal priority does not interrupt.
- R6: The winner is the eligible source with the numerically highest priority. Among sources with equal priority, the lowest-numbered source wins.
- R7: An `ack` pulse taken while `irq` is high has three effects from the next cycle on. `ack_vec` shows the winner's handler address, `ack_src` shows its index, and `ack_hit` is 1. In ranked mode the winner's priority also becomes the new threshold, which reads back at address 0x04.
- R8: An `ack` pulse taken while `irq` is low loads `ack_vec` from the default address register 0x02 and sets `ack_src` to 0 and `ack_hit` to 0. The threshold is left unchanged.
- R9: A write of any data to address 0x03 pops the in-service stack and restores the threshold that was in force before the matching acknowledge. The write is ignored when the stack is empty, and also when an acknowledge push happens in the same cycle.
- R10: After reset, all enables, priorities, handler addresses and the default address are 0. The block is in flat mode, the stack is empty, and `irq` and `ack_hit` are low.
- R11: The priority of source i is at address 0x10+i, in the low PRIO_W bits. The handler address of source i is at address 0x20+i. Both read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | N_SRC | Level request lines, one per source |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | VEC_W | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | VEC_W | Register read data, combinational on address |
| ack | input | 1 | Acknowledge pulse from the core |
| irq | output | 1 | Interrupt request to the core |
| ack_vec | output | VEC_W | Handler address returned by the last acknowledge |
| ack_src | output | SRC_W | Source index returned by the last acknowledge |
| ack_hit | output | 1 | 1 when the last acknowledge served a source |

## Verification
The checker watches several properties on every cycle:
- `irq` stays low whenever all enables are off or nothing is pending.
- A ranked-mode acknowledge always raises the threshold.
- An end-of-service write on a non-empty stack always lowers the threshold.
- An acknowledge with `irq` low always returns the default address.

Other behaviour can only be shown by the bench's scenarios. That includes which source wins an equal-priority tie and whether an equal priority is correctly refused. It also includes the one-cycle sampling latency, register read-back, and the exact handler address and index delivered after a nested sequence of acknowledges and pops.

// File: rtl/pic_pkg.sv
package pic_pkg;
   // word offsets inside the block's register window
   localparam int OFF_MASK  = 'h00;
   localparam int OFF_PEND  = 'h01;
   localparam int OFF_DEFV  = 'h02;
   localparam int OFF_EOI   = 'h03;
   localparam int OFF_LEVEL = 'h04;
   localparam int OFF_MODE  = 'h05;
   localparam int OFF_PRIO  = 'h10;
   localparam int OFF_VEC   = 'h20;
   localparam int WIN_SPAN  = 16;   // entries per per-source window
endpackage

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
   parameter int N_SRC  = 16,
   parameter int PRIO_W = 4,
   parameter int SRC_W  = 4
) (
   input  logic [N_SRC-1:0]             cand,
   input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
   output logic                         win_valid,
   output logic [SRC_W-1:0]             win_idx,
   output logic [PRIO_W-1:0]            win_prio
);
   // scan from the top index down; >= lets a lower index take a tie
   always_comb begin
      win_valid = 1'b0;
      win_idx   = '0;
      win_prio  = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (cand[i] && (!win_valid || prio[i] >= win_prio)) begin
            win_valid = 1'b1;
            win_idx   = SRC_W'(i);
            win_prio  = prio[i];
         end
      end
   end
endmodule

// File: rtl/pic_stack.sv
module pic_stack #(
   parameter int PRIO_W = 4,
   parameter int DEPTH  = 15,
   localparam int SP_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [PRIO_W-1:0] push_val,
   output logic [PRIO_W-1:0] top,
   output logic [SP_W-1:0]   level
);
   logic [DEPTH-1:0][PRIO_W-1:0] stk;
   logic [SP_W-1:0]              sp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp  <= '0;
         stk <= '0;
      end else if (push && sp != SP_W'(DEPTH)) begin
         stk[sp] <= push_val;
         sp      <= sp + 1'b1;
      end else if (pop && sp != '0) begin
         sp <= sp - 1'b1;
      end
   end

   assign top   = (sp == '0) ? '0 : stk[sp - 1'b1];
   assign level = sp;
endmodule

// File: rtl/pic_regs.sv
module pic_regs import pic_pkg::*; #(
   parameter int N_SRC  = 16,
   parameter int PRIO_W = 4,
   parameter int VEC_W  = 32,
   parameter int ADDR_W = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            addr,
   input  logic [VEC_W-1:0]             wdata,
   input  logic                         we,
   output logic [VEC_W-1:0]             rdata,
   input  logic [N_SRC-1:0]             pend,
   input  logic [PRIO_W-1:0]            cur_pri,
   output logic [N_SRC-1:0]             mask,
   output logic                         vec_mode,
   output logic [VEC_W-1:0]             defvec,
   output logic [N_SRC-1:0][PRIO_W-1:0] prio_tbl,
   output logic [N_SRC-1:0][VEC_W-1:0]  vec_tbl,
   output logic                         eoi
);
   function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
      return a == ADDR_W'(off);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask     <= '0;
         vec_mode <= 1'b0;
         defvec   <= '0;
      end else if (we) begin
         if (hit(addr, OFF_MASK)) mask     <= wdata[N_SRC-1:0];
         if (hit(addr, OFF_MODE)) vec_mode <= wdata[0];
         if (hit(addr, OFF_DEFV)) defvec   <= wdata;
      end
   end

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prio_tbl[g] <= '0;
            vec_tbl[g]  <= '0;
         end else if (we) begin
            if (hit(addr, OFF_PRIO + g)) prio_tbl[g] <= wdata[PRIO_W-1:0];
            if (hit(addr, OFF_VEC + g))  vec_tbl[g]  <= wdata;
         end
      end
   end

   assign eoi = we && hit(addr, OFF_EOI);

   always_comb begin
      rdata = '0;
      if (hit(addr, OFF_MASK))  rdata[N_SRC-1:0]  = mask;
      if (hit(addr, OFF_PEND))  rdata[N_SRC-1:0]  = pend;
      if (hit(addr, OFF_DEFV))  rdata             = defvec;
      if (hit(addr, OFF_LEVEL)) rdata[PRIO_W-1:0] = cur_pri;
      if (hit(addr, OFF_MODE))  rdata[0]          = vec_mode;
      for (int i = 0; i < N_SRC; i++) begin
         if (hit(addr, OFF_PRIO + i)) rdata[PRIO_W-1:0] = prio_tbl[i];
         if (hit(addr, OFF_VEC + i))  rdata             = vec_tbl[i];
      end
   end
endmodule

// File: rtl/prio_vic.sv
module prio_vic import pic_pkg::*; #(
   parameter int N_SRC  = 16,
   parameter int PRIO_W = 4,
   parameter int VEC_W  = 32,
   parameter int ADDR_W = 6,
   parameter int DEPTH  = (1 << PRIO_W) - 1,
   localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
   localparam int SP_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_req,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [VEC_W-1:0]  reg_wdata,
   input  logic              reg_we,
   output logic [VEC_W-1:0]  reg_rdata,
   input  logic              ack,
   output logic              irq,
   output logic [VEC_W-1:0]  ack_vec,
   output logic [SRC_W-1:0]  ack_src,
   output logic              ack_hit
);
   if (N_SRC < 1 || N_SRC > WIN_SPAN) begin : g_bad_nsrc
      $error("prio_vic: N_SRC must lie in 1..%0d", WIN_SPAN);
   end
   if (OFF_VEC + WIN_SPAN > (1 << ADDR_W)) begin : g_bad_addr
      $error("prio_vic: ADDR_W too narrow for the register window");
   end
   if (VEC_W < N_SRC || VEC_W < PRIO_W) begin : g_bad_vec
      $error("prio_vic: VEC_W must cover the bitmap and priority fields");
   end
   if (DEPTH < (1 << PRIO_W) - 1) begin : g_bad_depth
      $error("prio_vic: DEPTH must cover every nesting level");
   end

   logic [N_SRC-1:0]             req_q, mask, pend, prio_nz, cand;
   logic [N_SRC-1:0][PRIO_W-1:0] prio_tbl;
   logic [N_SRC-1:0][VEC_W-1:0]  vec_tbl;
   logic [VEC_W-1:0]             defvec;
   logic                         vec_mode, eoi, irq_c, push;
   logic                         win_valid;
   logic [SRC_W-1:0]             win_idx;
   logic [PRIO_W-1:0]            win_prio, cur_pri;
   logic [SP_W-1:0]              sp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= irq_req;
   end

   assign pend = req_q & mask;

   for (genvar g = 0; g < N_SRC; g++) begin : g_nz
      assign prio_nz[g] = |prio_tbl[g];
   end

   assign cand = vec_mode ? (pend & prio_nz) : pend;

   pic_regs #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
      .rdata(reg_rdata), .pend(pend), .cur_pri(cur_pri), .mask(mask),
      .vec_mode(vec_mode), .defvec(defvec), .prio_tbl(prio_tbl), .vec_tbl(vec_tbl),
      .eoi(eoi)
   );

   pic_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_arb (
      .cand(cand), .prio(prio_tbl), .win_valid(win_valid), .win_idx(win_idx),
      .win_prio(win_prio)
   );

   assign irq_c = vec_mode ? (win_valid && win_prio > cur_pri) : (|pend);
   assign push  = ack && irq_c && vec_mode;

   pic_stack #(.PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_stk (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(eoi), .push_val(win_prio),
      .top(cur_pri), .level(sp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_vec <= '0;
         ack_src <= '0;
         ack_hit <= 1'b0;
      end else if (ack) begin
         if (irq_c) begin
            ack_vec <= vec_tbl[win_idx];
            ack_src <= win_idx;
            ack_hit <= 1'b1;
         end else begin
            ack_vec <= defvec;
            ack_src <= '0;
            ack_hit <= 1'b0;
         end
      end
   end

   assign irq = irq_c;
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
   parameter int N_SRC  = 16,
   parameter int PRIO_W = 4,
   parameter int VEC_W  = 32,
   parameter int DEPTH  = 15,
   parameter int SP_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq,
   input logic              ack,
   input logic              ack_hit,
   input logic [VEC_W-1:0]  ack_vec,
   input logic [VEC_W-1:0]  defvec,
   input logic [N_SRC-1:0]  mask,
   input logic [N_SRC-1:0]  pend,
   input logic              vec_mode,
   input logic              eoi,
   input logic [PRIO_W-1:0] cur_pri,
   input logic [SP_W-1:0]   sp
);
   AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !irq); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |-> !irq); // R4
   AST_ACK_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq && vec_mode) |=> (cur_pri > $past(cur_pri))); // R7
   AST_DEFAULT_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !irq) |=> (!ack_hit && ack_vec == $past(defvec))); // R8
   AST_EOI_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !(ack && irq && vec_mode) && sp != '0) |=> (cur_pri < $past(cur_pri))); // R9
   AST_SP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      sp <= SP_W'(DEPTH)); // R9
endmodule

bind prio_vic pic_checker #(
   .N_SRC(N_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .DEPTH(DEPTH), .SP_W(SP_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq(irq), .ack(ack), .ack_hit(ack_hit),
   .ack_vec(ack_vec), .defvec(defvec), .mask(mask), .pend(pend),
   .vec_mode(vec_mode), .eoi(eoi), .cur_pri(cur_pri), .sp(sp)
);

// File: tb/tb_prio_vic.sv
module tb_prio_vic;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] req = '0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        we = 1'b0;
   logic        ack = 1'b0;
   logic [31:0] rdata, ack_vec;
   logic [3:0]  ack_src;
   logic        irq, ack_hit;

   always #5 clk = ~clk;

   prio_vic dut (
      .clk(clk), .rst_n(rst_n), .irq_req(req), .reg_addr(addr), .reg_wdata(wdata),
      .reg_we(we), .reg_rdata(rdata), .ack(ack), .irq(irq), .ack_vec(ack_vec),
      .ack_src(ack_src), .ack_hit(ack_hit)
   );

   int n_chk = 0;
   int n_bad = 0;

   // bench reference state
   logic [15:0] m_mask = '0, m_req_q = '0;
   logic [31:0] m_def = '0;
   logic [31:0] m_vec [16];
   int          m_prio [16];
   int          m_stk [16];
   int          m_sp = 0;
   bit          m_mode = 1'b0;
   logic [31:0] e_vec = '0;
   int          e_src = 0;
   bit          e_hit = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int f_win();
      int b = -1;
      for (int i = 15; i >= 0; i--) begin
         if (m_req_q[i] && m_mask[i] && (!m_mode || m_prio[i] != 0))
            if (b < 0 || m_prio[i] >= m_prio[b]) b = i;
      end
      return b;
   endfunction

   function automatic int f_cur();
      return (m_sp > 0) ? m_stk[m_sp-1] : 0;
   endfunction

   function automatic bit f_irq();
      int w = f_win();
      if (m_mode) return (w >= 0) && (m_prio[w] > f_cur());
      return (m_req_q & m_mask) != 0;
   endfunction

   task automatic cyc(input logic [15:0] r, input bit a, input bit w,
                      input logic [5:0] ad, input logic [31:0] wd);
      int  win;
      bit  ip;
      req = r; ack = a; we = w; addr = ad; wdata = wd;
      @(posedge clk); #1;
      win = f_win();
      ip  = f_irq();
      if (a) begin
         if (ip) begin e_vec = m_vec[win]; e_src = win; e_hit = 1'b1; end
         else    begin e_vec = m_def;      e_src = 0;   e_hit = 1'b0; end
      end
      if (a && ip && m_mode) begin
         m_stk[m_sp] = m_prio[win];
         m_sp++;
      end else if (w && ad == 6'h03 && m_sp > 0) begin
         m_sp--;
      end
      if (w) begin
         if (ad == 6'h00) m_mask = wd[15:0];
         if (ad == 6'h02) m_def  = wd;
         if (ad == 6'h05) m_mode = wd[0];
         if (ad >= 6'h10 && ad <= 6'h1F) m_prio[ad[3:0]] = int'(wd[3:0]);
         if (ad >= 6'h20 && ad <= 6'h2F) m_vec[ad[3:0]]  = wd;
      end
      m_req_q = r;
      ack = 1'b0; we = 1'b0;
      chk(irq == f_irq(), m_mode ? "R5 irq" : "R4 irq", 32'(irq), 32'(f_irq()));
      if (a) begin
         chk(ack_hit == e_hit, ip ? "R7 hit" : "R8 hit", 32'(ack_hit), 32'(e_hit));
         chk(ack_vec == e_vec, ip ? "R7 vector" : "R8 vector", ack_vec, e_vec);
         chk(int'(ack_src) == e_src, ip ? "R7 source" : "R8 source", 32'(ack_src), 32'(e_src));
      end
   endtask

   task automatic rd(input logic [5:0] ad, input logic [31:0] exp, input string tag);
      addr = ad; we = 1'b0;
      #1;
      chk(rdata == exp, tag, rdata, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int seed;
      for (int i = 0; i < 16; i++) begin m_vec[i] = '0; m_prio[i] = 0; m_stk[i] = 0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      // R10: reset state
      chk(irq == 1'b0, "R10 irq", 32'(irq), 0);
      chk(ack_hit == 1'b0, "R10 ack_hit", 32'(ack_hit), 0);
      chk(ack_vec == '0, "R10 ack_vec", ack_vec, 0);
      rd(6'h00, 0, "R10 mask");
      rd(6'h02, 0, "R10 default");
      rd(6'h04, 0, "R10 level");
      rd(6'h05, 0, "R10 mode");

      // R11: per-source programming and read-back
      for (int i = 0; i < 16; i++) cyc(0, 0, 1, 6'(16 + i), 32'((i * 7) % 16));
      for (int i = 0; i < 16; i++) cyc(0, 0, 1, 6'(32 + i), 32'h4000_0000 + 32'(i * 256));
      rd(6'h13, 32'((3 * 7) % 16), "R11 prio read");
      rd(6'h25, 32'h4000_0500, "R11 vec read");

      // R2/R3/R4: flat mode
      cyc(16'h0001, 0, 0, 0, 0);
      chk(irq == 1'b0, "R2 masked", 32'(irq), 0);
      rd(6'h01, 0, "R3 pend masked");
      cyc(16'h0001, 0, 1, 6'h00, 32'h0000_FFFF);
      chk(irq == 1'b1, "R4 flat irq", 32'(irq), 1);
      rd(6'h01, 32'h0001, "R3 pend");
      // R1: sampling latency
      req = 16'h0000; #1;
      chk(irq == 1'b1, "R1 before edge", 32'(irq), 1);
      cyc(16'h0000, 0, 0, 0, 0);
      chk(irq == 1'b0, "R1 after edge", 32'(irq), 0);
      cyc(16'h0011, 0, 0, 0, 0);
      cyc(16'h0011, 1, 0, 0, 0);

      // ranked mode: R5/R6/R7/R9
      cyc(0, 0, 1, 6'h05, 1);
      cyc(0, 0, 1, 6'h12, 5);
      cyc(0, 0, 1, 6'h17, 5);
      cyc(0, 0, 1, 6'h19, 3);
      cyc(0, 0, 1, 6'h1B, 8);
      cyc(16'h0284, 0, 0, 0, 0);
      cyc(16'h0284, 1, 0, 0, 0);
      chk(ack_src == 4'd2, "R6 tie lowest index", 32'(ack_src), 2);
      rd(6'h04, 5, "R7 threshold");
      chk(irq == 1'b0, "R5 equal refused", 32'(irq), 0);
      cyc(16'h0A84, 0, 0, 0, 0);
      chk(irq == 1'b1, "R5 outranks", 32'(irq), 1);
      cyc(16'h0A84, 1, 0, 0, 0);
      chk(ack_src == 4'd11, "R7 nested source", 32'(ack_src), 11);
      rd(6'h04, 8, "R7 nested threshold");
      cyc(16'h0A84, 0, 1, 6'h03, 0);
      rd(6'h04, 5, "R9 pop restores");
      cyc(16'h0A84, 0, 1, 6'h03, 0);
      rd(6'h04, 0, "R9 pop to idle");
      chk(irq == 1'b1, "R9 irq after pop", 32'(irq), 1);

      // R8: default vector
      cyc(0, 0, 1, 6'h02, 32'hDEAD_0000);
      cyc(0, 1, 0, 0, 0);
      chk(ack_vec == 32'hDEAD_0000, "R8 default", ack_vec, 32'hDEAD_0000);
      rd(6'h04, 0, "R8 no push");
      cyc(0, 0, 1, 6'h03, 0);
      rd(6'h04, 0, "R9 empty pop ignored");
      // R2 in ranked mode
      cyc(16'h0800, 0, 1, 6'h00, 32'h0000_F7FF);
      cyc(16'h0800, 0, 0, 0, 0);
      chk(irq == 1'b0, "R2 ranked masked", 32'(irq), 0);
      cyc(0, 0, 1, 6'h00, 32'h0000_FFFF);

      // constrained random traffic
      seed = $urandom(32'd2024);
      for (int n = 0; n < 4000; n++) begin
         logic [15:0] r = 16'($urandom) & 16'($urandom);
         int k = int'($urandom % 16);
         if (k == 0)      cyc(r, 0, 1, 6'(16 + $urandom % 16), 32'($urandom % 16));
         else if (k == 1) cyc(r, 0, 1, 6'h03, 0);
         else if (k == 2) cyc(r, 0, 1, 6'h00, 32'($urandom));
         else if (k == 3 && $urandom % 20 == 0) cyc(r, 0, 1, 6'h05, 32'($urandom % 2));
         else if (k < 7)  cyc(r, 1, 0, 0, 0);
         else             cyc(r, 0, 0, 0, 0);
         if (n % 64 == 0) rd(6'h04, 32'(f_cur()), "R9 random threshold");
         if (n % 64 == 32) rd(6'h01, 32'(m_req_q & m_mask), "R3 random pend");
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule